// File: doc/BRIEF.md
# Audio Master-Clock Timing Generator

This block derives every sample-rate timing signal for a stereo delta-sigma converter from a single master clock. A two-bit mode input sets both the ratio of the master clock to the sample rate and the oversampling rate of the modulator. From these it produces three things: a bit clock at 64 times the sample rate, a word clock at the sample rate, and a strobe that clocks the modulator at 64 or 32 times the sample rate.

Every output lives in the master-clock domain. The bit clock and word clock come out as registered levels, ready to drive a serial audio port in master mode. Four single-cycle enables also come out, and each one is high in the master-clock cycle whose closing edge moves the corresponding event. Downstream logic can therefore act on the same edge with no further decoding.

Mode codes:
- `00`: master clock of 256 fs, 64 fs oversampling.
- `01`: master clock of 384 fs, 64 fs oversampling.
- `10` and `11`: master clock of 128 fs, 32 fs oversampling. These codes are used above 96 kHz.

All counters clear on reset, so the first word-clock half always belongs to the left channel.

Top module: `aclk_timing_gen`

## Requirements
- R1: While `rstN` is low, `bitClk` and `wordClk` are 0 and `osEn`, `bckRiseEn`, `bckFallEn` and `lrFlipEn` are all 0.
- R2: The `bitClk` period is 4 master-clock cycles for `modeSel`=00, 6 for 01 and 2 for 10 or 11. In each period it is low for the first half and high for the second, starting low after reset release.
- R3: `bckRiseEn` is 1 exactly in the cycle before `bitClk` goes from 0 to 1. `bckFallEn` is 1 exactly in the cycle before `bitClk` goes from 1 to 0.
- R4: `wordClk` toggles only on an edge where `bitClk` falls, once per 32 `bitClk` periods. It is 0 (left channel) for the first 32 bit-clock periods after reset release.
- R5: `lrFlipEn` is 1 exactly in the cycle before `wordClk` toggles.
- R6: `osEn` pulses for one cycle in the last cycle of every 4 master cycles for mode 00, every 6 for 01 and every 4 for 10 or 11. Counting the cycle of reset release as 0, the first pulse comes in cycle 3, 5 and 3 respectively.
- R7: In modes 00 and 01, held since reset, each `osEn` pulse coincides with a `bckFallEn` pulse.
- R8: If `modeSel` changes without reset and the bit-clock phase is already at or past the last phase of the new ratio, `bckFallEn` is 1 at once, and the phase restarts at the next edge.
- R9: `bckRiseEn` and `bckFallEn` are never 1 in the same cycle, and `osEn` is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 2 | Ratio and oversampling code |
| osEn | output | 1 | Modulator oversampling enable |
| bckRiseEn | output | 1 | Bit clock rises at the closing edge |
| bckFallEn | output | 1 | Bit clock falls at the closing edge |
| lrFlipEn | output | 1 | Word clock toggles at the closing edge |
| bitClk | output | 1 | Bit clock level, 64 fs |
| wordClk | output | 1 | Word clock level, 0 = left channel |

## Verification
Some properties are checked on every cycle:
- The bit clock follows its rise and fall strobes into the next cycle.
- The word clock moves only with a falling bit clock.
- Rise and fall strobes never collide.
- The oversampling strobe never repeats back to back.
- The phase counter restarts after each fall.

The exact divide ratios per mode, the position of the first oversampling pulse, the left-channel first half and the 32-bit word length can only be shown by the bench's scenarios. The same holds for alignment of the oversampling strobe with the bit clock and for a mid-run change from the 384 fs to the 256 fs ratio. For these the bench runs a behavioural reference cycle by cycle.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  typedef struct packed {
    logic osTick;
    logic bckRise;
    logic bckFall;
    logic lrFlip;
  } aclkStrobe_t;

  typedef enum logic [1:0] {
    MODE_R256  = 2'b00,
    MODE_R384  = 2'b01,
    MODE_R128A = 2'b10,
    MODE_R128B = 2'b11
  } aclkMode_e;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/aclk_ctrl.sv
module aclk_ctrl
  import aclk_pkg::*;
#(
  parameter int DIV256    = 4,
  parameter int DIV384    = 6,
  parameter int DIV128    = 2,
  parameter int OS128     = 4,
  parameter int HALF_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  modeSel,
  output aclkStrobe_t strobe
);

  localparam int MAX_DIV = maxOf(maxOf(DIV256, DIV384), maxOf(DIV128, OS128));
  localparam int CW      = $clog2(MAX_DIV + 1);
  localparam int BW      = $clog2(HALF_BITS);

  logic [CW-1:0] bckDiv;
  logic [CW-1:0] bckHalf;
  logic [CW-1:0] osDiv;
  logic [CW-1:0] divCnt;
  logic [CW-1:0] osCnt;
  logic [BW-1:0] bitIdx;
  logic          endTick;
  logic          midTick;
  logic          osEnd;
  logic          lastBit;

  // ratio decode: bit-clock divider and oversampling divider per mode
  always_comb begin
    case (aclkMode_e'(modeSel))
      MODE_R256: begin
        bckDiv = CW'(DIV256);
        osDiv  = CW'(DIV256);
      end
      MODE_R384: begin
        bckDiv = CW'(DIV384);
        osDiv  = CW'(DIV384);
      end
      default: begin
        bckDiv = CW'(DIV128);
        osDiv  = CW'(OS128);
      end
    endcase
    bckHalf = bckDiv >> 1;
  end

  // a phase at or beyond the last one wraps, which keeps live mode changes safe
  assign endTick = (divCnt >= (bckDiv - CW'(1)));
  assign midTick = (divCnt == (bckHalf - CW'(1)));
  assign osEnd   = (osCnt >= (osDiv - CW'(1)));
  assign lastBit = (bitIdx == BW'(HALF_BITS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      osCnt  <= '0;
      bitIdx <= '0;
    end else begin
      divCnt <= endTick ? '0 : divCnt + CW'(1);
      osCnt  <= osEnd ? '0 : osCnt + CW'(1);
      if (endTick) begin
        bitIdx <= lastBit ? '0 : bitIdx + BW'(1);
      end
    end
  end

  assign strobe.bckRise = rstN & midTick;
  assign strobe.bckFall = rstN & endTick;
  assign strobe.osTick  = rstN & osEnd;
  assign strobe.lrFlip  = rstN & endTick & lastBit;

  // R9: rise and fall strobes are mutually exclusive
  a_r9_rise_fall_apart: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.bckRise && strobe.bckFall));

  // R9: oversampling strobe is a single-cycle pulse
  a_r9_os_single: assert property (@(posedge clk) disable iff (!rstN)
    strobe.osTick |=> !strobe.osTick);

  // R8: a fall strobe always restarts the bit-clock phase
  a_r8_phase_restart: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bckFall |=> (divCnt == '0));

endmodule

// File: rtl/aclk_datapath.sv
module aclk_datapath
  import aclk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  aclkStrobe_t strobe,
  output logic        bitClk,
  output logic        wordClk
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitClk  <= 1'b0;
      wordClk <= 1'b0;
    end else begin
      if (strobe.bckRise) begin
        bitClk <= 1'b1;
      end else if (strobe.bckFall) begin
        bitClk <= 1'b0;
      end
      if (strobe.lrFlip) begin
        wordClk <= ~wordClk;
      end
    end
  end

  // R3: the bit clock follows its strobes on the next cycle
  a_r3_rise_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bckRise |=> bitClk);

  a_r3_fall_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bckFall |=> !bitClk);

  // R4: the word clock only moves together with a falling bit clock
  a_r4_lr_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wordClk) |-> $fell(bitClk));

endmodule

// File: rtl/aclk_timing_gen.sv
module aclk_timing_gen
  import aclk_pkg::*;
#(
  parameter int DIV256    = 4,
  parameter int DIV384    = 6,
  parameter int DIV128    = 2,
  parameter int OS128     = 4,
  parameter int HALF_BITS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  output logic       osEn,
  output logic       bckRiseEn,
  output logic       bckFallEn,
  output logic       lrFlipEn,
  output logic       bitClk,
  output logic       wordClk
);

  aclkStrobe_t strobe;

  aclk_ctrl #(
    .DIV256   (DIV256),
    .DIV384   (DIV384),
    .DIV128   (DIV128),
    .OS128    (OS128),
    .HALF_BITS(HALF_BITS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .modeSel(modeSel),
    .strobe (strobe)
  );

  aclk_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .bitClk (bitClk),
    .wordClk(wordClk)
  );

  assign osEn      = strobe.osTick;
  assign bckRiseEn = strobe.bckRise;
  assign bckFallEn = strobe.bckFall;
  assign lrFlipEn  = strobe.lrFlip;

endmodule

// File: tb/aclk_timing_gen_bench.sv
`timescale 1ns/1ps
module aclk_timing_gen_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] modeSel;
  logic       osEn, bckRiseEn, bckFallEn, lrFlipEn, bitClk, wordClk;

  always #2.5 clk = ~clk;

  aclk_timing_gen u_aclk_timing_gen (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .osEn     (osEn),
    .bckRiseEn(bckRiseEn),
    .bckFallEn(bckFallEn),
    .lrFlipEn (lrFlipEn),
    .bitClk   (bitClk),
    .wordClk  (wordClk)
  );

  int checks = 0;
  int failures = 0;

  // reference state, kept as plain integers
  int mPh, mOs, mBit;
  bit mBck, mLr;

  function automatic int bckPeriod(input logic [1:0] m);
    case (m)
      2'b00:   return 4;
      2'b01:   return 6;
      default: return 2;
    endcase
  endfunction

  function automatic int osPeriod(input logic [1:0] m);
    case (m)
      2'b01:   return 6;
      default: return 4;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 0; mOs = 0; mBit = 0; mBck = 0; mLr = 0;
    end else begin
      int d, o;
      bit fall, rise;
      d = bckPeriod(modeSel);
      o = osPeriod(modeSel);
      fall = (mPh >= d - 1);
      rise = (mPh == d / 2 - 1);
      if (fall) begin
        mPh = 0;
        mBck = 0;
        if (mBit == 31) begin
          mBit = 0;
          mLr = !mLr;
        end else begin
          mBit++;
        end
      end else begin
        mPh++;
        if (rise) mBck = 1;
      end
      if (mOs >= o - 1) mOs = 0; else mOs++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmpAll();
    int d, o;
    bit eFall, eRise, eOs, eFlip;
    d = bckPeriod(modeSel);
    o = osPeriod(modeSel);
    eFall = (mPh >= d - 1);
    eRise = (mPh == d / 2 - 1);
    eOs   = (mOs >= o - 1);
    eFlip = eFall && (mBit == 31);
    chk(bitClk == mBck, "R2 bitClk", int'(bitClk), int'(mBck));
    chk(bckRiseEn == eRise, "R3 bckRiseEn", int'(bckRiseEn), int'(eRise));
    chk(bckFallEn == eFall, "R3 bckFallEn", int'(bckFallEn), int'(eFall));
    chk(wordClk == mLr, "R4 wordClk", int'(wordClk), int'(mLr));
    chk(lrFlipEn == eFlip, "R5 lrFlipEn", int'(lrFlipEn), int'(eFlip));
    chk(osEn == eOs, "R6 osEn", int'(osEn), int'(eOs));
    chk(!(bckRiseEn && bckFallEn), "R9 strobe overlap", int'(bckRiseEn && bckFallEn), 0);
  endtask

  task automatic doReset(input logic [1:0] m);
    @(negedge clk);
    rstN = 1'b0;
    modeSel = m;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(bitClk == 1'b0 && wordClk == 1'b0, "R1 levels",
        int'({bitClk, wordClk}), 0);
    chk({osEn, bckRiseEn, bckFallEn, lrFlipEn} == 4'b0, "R1 enables",
        int'({osEn, bckRiseEn, bckFallEn, lrFlipEn}), 0);
    rstN = 1'b1;
  endtask

  task automatic runMode(input logic [1:0] m, input int n);
    int d, o, prevOs, prevBck;
    d = bckPeriod(m);
    o = osPeriod(m);
    prevOs = -1;
    prevBck = -1;
    doReset(m);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      cmpAll();
      // R6: position of the first oversampling pulse
      if (k < o - 1) chk(!osEn, "R6 early osEn", int'(osEn), 0);
      if (k == o - 1) chk(osEn, "R6 first osEn", int'(osEn), 1);
      // R6: spacing between pulses
      if (osEn) begin
        if (prevOs >= 0) chk(k - prevOs == o, "R6 os spacing", k - prevOs, o);
        prevOs = k;
      end
      // R2: bit clock period measured at rises
      if (bckRiseEn) begin
        if (prevBck >= 0) chk(k - prevBck == d, "R2 bck period", k - prevBck, d);
        prevBck = k;
      end
      // R4: left channel for the first 32 bit periods
      if (k == 32 * d - 1) chk(wordClk == 1'b0, "R4 left first", int'(wordClk), 0);
      if (k == 32 * d) chk(wordClk == 1'b1, "R4 right after 32", int'(wordClk), 1);
      // R7: alignment of oversampling with bit-clock falls
      if (m[1] == 1'b0 && osEn) chk(bckFallEn, "R7 os aligned", int'(bckFallEn), 1);
    end
  endtask

  task automatic modeSwitch();
    doReset(2'b01);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      cmpAll();
    end
    // phase is 4; it is not the end for the 384 fs ratio
    chk(!bckFallEn, "R8 before switch", int'(bckFallEn), 0);
    modeSel = 2'b00;
    #1;
    // R8: phase 4 is past the last phase of the 256 fs ratio
    chk(bckFallEn, "R8 wrap on switch", int'(bckFallEn), 1);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      cmpAll();
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    modeSel = 2'b00;
    runMode(2'b00, 600);
    runMode(2'b01, 900);
    runMode(2'b10, 400);
    runMode(2'b11, 400);
    modeSwitch();
    // reset again mid-frame, back to 256 fs
    runMode(2'b00, 300);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule